// File: doc/BRIEF.md
# Power-Up Strap Sampling Controller

This block manages two pins that first act as configuration inputs and then become clock outputs. When the supply-good input asserts, a window timer that runs on the reference clock begins counting. For the whole window both pin output enables stay low, so the pin drivers are in high impedance and the external pull resistors set each pin's level. On the last cycle of the window, the synchronized level of each pin is captured as a strap bit. Both drivers are then enabled for the rest of the powered period, and a status output reports that sampling has finished.

The two strap bits form a frequency-select code, which is decoded into a CPU clock rate and a memory clock rate in MHz. A register-write strobe from an external serial engine can load an override code together with a valid flag. While that flag is set, the override code is used in place of the straps. The straps are not cleared by the logic reset. Only loss of supply-good clears them and starts the sampling sequence again.

Top module: `strap_sampler_top`

## Requirements
- R1: With supply-good held high, `sample_done` rises at the clock edge that is the WIN_CYCLES-th rising edge seen with supply-good high. It is low before that edge.
- R2: While supply-good is low the window timer stays at its start value. Dropping supply-good for one cycle inside the window restarts a full window.
- R3: `pin_oe` is 2'b00 while `sample_done` is low and 2'b11 once it is high.
- R4: At window end, `strap_bits[i]` takes the level of `pin_in[i]` after a two-flop synchronizer: low gives 0 and high gives 1. Pin changes after capture do not affect `strap_bits`.
- R5: `sample_done` stays high until supply-good drops.
- R6: Asserting `rst_n` (active low, synchronous) does not clear `strap_bits`, `sample_done` or `pin_oe`.
- R7: `fsel_code[1]` is the high select bit. The decode is: 00 gives CPU 66 and memory 100; 01 gives 100 and 100; 10 gives 133 and 133; 11 gives 133 and 100.
- R8: A cycle with `ovr_wr_en` high loads `ovr_wr_data`, where bit 2 is the valid flag and bits 1:0 are the code. From the next cycle, a set valid flag makes `fsel_code` equal the written code, and a clear valid flag returns it to `strap_bits`.
- R9: The override valid flag is cleared when supply-good is low or when `rst_n` is low.
- R10: A clock edge with supply-good low clears `strap_bits` to 00 and `sample_done` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low logic reset |
| supply_good | input | 1 | I/O supply above threshold |
| pin_in | input | 2 | Level sensed on the dual-purpose pins |
| pin_oe | output | 2 | Output-driver enables for the pins |
| sample_done | output | 1 | Window over, straps latched, drivers on |
| strap_bits | output | 2 | Latched strap values |
| ovr_wr_en | input | 1 | Override register write strobe |
| ovr_wr_data | input | 3 | {valid, code[1:0]} |
| fsel_code | output | 2 | Active frequency-select code |
| cpu_mhz | output | 8 | Decoded CPU clock rate |
| mem_mhz | output | 8 | Decoded memory clock rate |

## Verification
The bench samples with pins strapped to 10. It then re-samples with pins strapped to 11 after a power cycle, so that capture is shown to follow the pin levels and not a value kept from before. It checks the window at its last-but-one and its final edge, and it repeats the window after a one-cycle supply-good dropout, to separate a correct count from one that is off by one or does not restart. Override writes with codes 01, 00 and 11, a write that clears the valid flag, and a logic-reset pulse show which code source is selected, along with all four decode rows.

// File: rtl/strap_pkg.sv
// Package: shared types and the frequency-select decode for the strap sampler.
// Assumes fsel bit 1 is the high select bit.
package strap_pkg;
    typedef logic [1:0] fsel_t;

    typedef struct packed {
        logic [7:0] cpu;
        logic [7:0] mem;
    } freq_pair_t;

    // Map a select code onto CPU and memory rates in MHz.
    function automatic freq_pair_t decode_fsel(input fsel_t code);
        freq_pair_t r;
        case (code)
            2'b00:   begin r.cpu = 8'd66;  r.mem = 8'd100; end
            2'b01:   begin r.cpu = 8'd100; r.mem = 8'd100; end
            2'b10:   begin r.cpu = 8'd133; r.mem = 8'd133; end
            default: begin r.cpu = 8'd133; r.mem = 8'd100; end
        endcase
        return r;
    endfunction
endpackage

// File: rtl/strap_sync.sv
// Module: two-flop synchronizer, one lane per bit.
// Assumes the inputs are asynchronous to clk and quasi-static during sampling.
module strap_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_lane
        logic meta, stable;
        // Two register stages per bit to settle metastability.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta   <= 1'b0;
                stable <= 1'b0;
            end else begin
                meta   <= d[i];
                stable <= meta;
            end
        end
        assign q[i] = stable;
    end
endmodule

// File: rtl/strap_window_timer.sv
// Module: counts the sampling window once supply-good is high.
// Emits a one-cycle capture strobe on the final window cycle, then holds done.
// Only supply-good clears it; the logic reset has no effect by design.
module strap_window_timer #(
    parameter int WIN_CYCLES = 28636
) (
    input  logic clk,
    input  logic pwr_ok,
    output logic capture,
    output logic done
);
    localparam int CNT_W = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    // Strobe on the last counted cycle of an unfinished window.
    assign capture = pwr_ok && !done && (cnt == LAST);

    // Advance the window counter; restart whenever supply-good is low.
    always_ff @(posedge clk) begin
        if (!pwr_ok) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (capture) begin
            done <= 1'b1;
        end else if (!done) begin
            cnt  <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/strap_freq_sel.sv
// Module: holds the serially written override and picks the active select code,
// then decodes it into clock rates. The override is cleared at power-up or logic reset.
module strap_freq_sel
    import strap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_ok,
    input  logic       wr_en,
    input  logic [2:0] wr_data,
    input  fsel_t      straps,
    output fsel_t      fsel,
    output logic [7:0] cpu_mhz,
    output logic [7:0] mem_mhz
);
    logic  ovr_valid;
    fsel_t ovr_code;
    freq_pair_t rates;

    // Override register, loaded by the write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_ok) begin
            ovr_valid <= 1'b0;
            ovr_code  <= '0;
        end else if (wr_en) begin
            ovr_valid <= wr_data[2];
            ovr_code  <= wr_data[1:0];
        end
    end

    // Select the code source and decode it.
    always_comb begin
        fsel    = ovr_valid ? ovr_code : straps;
        rates   = decode_fsel(fsel);
        cpu_mhz = rates.cpu;
        mem_mhz = rates.mem;
    end
endmodule

// File: rtl/strap_sampler_top.sv
// Module: power-up strap sampling controller top.
// Holds the dual-purpose pins in high impedance for WIN_CYCLES after supply-good,
// latches their synchronized levels, then enables the drivers. WIN_CYCLES must be >= 3.
module strap_sampler_top
    import strap_pkg::*;
#(
    parameter int WIN_CYCLES = 28636,
    parameter int NUM_PINS   = 2
) (
    input  logic                clk_ref,
    input  logic                rst_n,
    input  logic                supply_good,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                sample_done,
    output logic [NUM_PINS-1:0] strap_bits,
    input  logic                ovr_wr_en,
    input  logic [2:0]          ovr_wr_data,
    output logic [1:0]          fsel_code,
    output logic [7:0]          cpu_mhz,
    output logic [7:0]          mem_mhz
);
    logic [NUM_PINS-1:0] pin_sync;
    logic                capture;
    logic                done;

    strap_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk(clk_ref), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
    );

    strap_window_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
        .clk(clk_ref), .pwr_ok(supply_good), .capture(capture), .done(done)
    );

    // Strap latches: loaded once per power cycle, cleared only by supply loss.
    always_ff @(posedge clk_ref) begin
        if (!supply_good)
            strap_bits <= '0;
        else if (capture)
            strap_bits <= pin_sync;
    end

    assign sample_done = done;
    assign pin_oe      = {NUM_PINS{done}};

    strap_freq_sel u_fsel (
        .clk(clk_ref), .rst_n(rst_n), .pwr_ok(supply_good),
        .wr_en(ovr_wr_en), .wr_data(ovr_wr_data),
        .straps(strap_bits[1:0]), .fsel(fsel_code),
        .cpu_mhz(cpu_mhz), .mem_mhz(mem_mhz)
    );
endmodule

// File: rtl/strap_sampler_chk.sv
// Checker: temporal properties of the strap sampler, bound to the top module.
module strap_sampler_chk (
    input logic       clk_ref,
    input logic       rst_n,
    input logic       supply_good,
    input logic [1:0] pin_in,
    input logic [1:0] pin_oe,
    input logic       sample_done,
    input logic [1:0] strap_bits,
    input logic       ovr_wr_en,
    input logic [2:0] ovr_wr_data,
    input logic [1:0] fsel_code,
    input logic [7:0] cpu_mhz,
    input logic [7:0] mem_mhz
);
    logic [1:0] age = 2'd0;

    // Count edges since supply-good rose, saturating, to guard $past depth.
    always_ff @(posedge clk_ref) begin
        if (!supply_good) age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    a_r10_power_clears: assert property (@(posedge clk_ref)
        !supply_good |=> (!sample_done && strap_bits == 2'b00));

    a_r3_oe_tracks_done: assert property (@(posedge clk_ref) disable iff (!supply_good)
        (age == 2'd3) |-> (pin_oe == (sample_done ? 2'b11 : 2'b00)));

    a_r5_done_sticky: assert property (@(posedge clk_ref) disable iff (!supply_good)
        (age == 2'd3 && $past(sample_done)) |-> sample_done);

    a_r4_straps_hold: assert property (@(posedge clk_ref) disable iff (!supply_good)
        (age == 2'd3 && $past(sample_done)) |-> $stable(strap_bits));

    a_r4_capture_value: assert property (@(posedge clk_ref) disable iff (!supply_good || !rst_n)
        (age == 2'd3 && $rose(sample_done) && $stable(pin_in) && pin_in == $past(pin_in, 3))
            |-> strap_bits == pin_in);

    a_r8_override_load: assert property (@(posedge clk_ref) disable iff (!supply_good || !rst_n)
        (ovr_wr_en && ovr_wr_data[2]) |=> fsel_code == $past(ovr_wr_data[1:0]));

    a_r7_decode_133_133: assert property (@(posedge clk_ref)
        fsel_code == 2'b10 |-> (cpu_mhz == 8'd133 && mem_mhz == 8'd133));

    a_r7_decode_66: assert property (@(posedge clk_ref)
        fsel_code == 2'b00 |-> (cpu_mhz == 8'd66 && mem_mhz == 8'd100));
endmodule

bind strap_sampler_top strap_sampler_chk u_chk (
    .clk_ref(clk_ref), .rst_n(rst_n), .supply_good(supply_good),
    .pin_in(pin_in[1:0]), .pin_oe(pin_oe[1:0]), .sample_done(sample_done),
    .strap_bits(strap_bits[1:0]), .ovr_wr_en(ovr_wr_en), .ovr_wr_data(ovr_wr_data),
    .fsel_code(fsel_code), .cpu_mhz(cpu_mhz), .mem_mhz(mem_mhz)
);

// File: tb/tb_strap_sampler_top.sv
`timescale 1ns/1ps
// Bench: scoreboard-style. The driver pushes expected output snapshots into a queue;
// a monitor pops them and compares them with the design outputs between clock edges.
module tb_strap_sampler_top;
    localparam int WIN = 16;

    typedef struct {
        string      req;
        logic [1:0] oe;
        logic       done;
        logic [1:0] strap;
        logic [1:0] fsel;
        logic [7:0] cpu;
        logic [7:0] mem;
    } exp_t;

    logic       clk_ref = 1'b0;
    logic       rst_n = 1'b0;
    logic       supply_good = 1'b0;
    logic [1:0] pin_in = 2'b10;
    logic       ovr_wr_en = 1'b0;
    logic [2:0] ovr_wr_data = 3'b000;
    logic [1:0] pin_oe, strap_bits, fsel_code;
    logic       sample_done;
    logic [7:0] cpu_mhz, mem_mhz;

    int   n_vec = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;
    exp_t sb_q[$];
    event chk_ev;

    strap_sampler_top #(.WIN_CYCLES(WIN), .NUM_PINS(2)) dut (
        .clk_ref(clk_ref), .rst_n(rst_n), .supply_good(supply_good),
        .pin_in(pin_in), .pin_oe(pin_oe), .sample_done(sample_done),
        .strap_bits(strap_bits), .ovr_wr_en(ovr_wr_en), .ovr_wr_data(ovr_wr_data),
        .fsel_code(fsel_code), .cpu_mhz(cpu_mhz), .mem_mhz(mem_mhz)
    );

    always #10 clk_ref = ~clk_ref;

    // Driver side: queue one expected snapshot and wake the monitor.
    task automatic expect_out(input string req, input logic [1:0] oe, input logic done,
                              input logic [1:0] strap, input logic [1:0] fsel,
                              input logic [7:0] cpu, input logic [7:0] mem);
        exp_t e;
        e.req = req; e.oe = oe; e.done = done; e.strap = strap;
        e.fsel = fsel; e.cpu = cpu; e.mem = mem;
        sb_q.push_back(e);
        ->chk_ev;
        #3;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk_ref);
    endtask

    task automatic write_ovr(input logic [2:0] data);
        ovr_wr_en = 1'b1; ovr_wr_data = data;
        @(negedge clk_ref);
        ovr_wr_en = 1'b0;
    endtask

    // Monitor: compare each queued snapshot with the live outputs.
    initial begin
        forever begin
            @(chk_ev);
            #1;
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_vec++;
                if (pin_oe !== e.oe || sample_done !== e.done || strap_bits !== e.strap ||
                    fsel_code !== e.fsel || cpu_mhz !== e.cpu || mem_mhz !== e.mem) begin
                    n_bad++;
                    $display("FAIL %s: got oe=%b done=%b strap=%b fsel=%b cpu=%0d mem=%0d, expected oe=%b done=%b strap=%b fsel=%b cpu=%0d mem=%0d",
                             e.req, pin_oe, sample_done, strap_bits, fsel_code, cpu_mhz, mem_mhz,
                             e.oe, e.done, e.strap, e.fsel, e.cpu, e.mem);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        cycles(3);
        // R10 reset state: supply low clears everything
        expect_out("R10 power-off state", 2'b00, 1'b0, 2'b00, 2'b00, 8'd66, 8'd100);
        rst_n = 1'b1;
        cycles(5);
        // R2 timer idle while supply-good is low
        expect_out("R2 idle without supply", 2'b00, 1'b0, 2'b00, 2'b00, 8'd66, 8'd100);

        supply_good = 1'b1;
        cycles(WIN - 1);
        // R1 R3 one edge before window end: still hi-Z
        expect_out("R1 R3 window not yet over", 2'b00, 1'b0, 2'b00, 2'b00, 8'd66, 8'd100);
        cycles(1);
        // R1 R4 R7 capture of pins=10 at window end
        expect_out("R1 R4 R7 capture 10", 2'b11, 1'b1, 2'b10, 2'b10, 8'd133, 8'd133);

        pin_in = 2'b01;
        cycles(4);
        // R4 R5 later pin changes ignored, done held
        expect_out("R4 R5 pins ignored after capture", 2'b11, 1'b1, 2'b10, 2'b10, 8'd133, 8'd133);

        rst_n = 1'b0;
        cycles(2);
        // R6 logic reset leaves straps and enables
        expect_out("R6 reset keeps straps", 2'b11, 1'b1, 2'b10, 2'b10, 8'd133, 8'd133);
        rst_n = 1'b1;
        cycles(1);

        write_ovr(3'b101);
        // R8 override code 01
        expect_out("R8 override 01", 2'b11, 1'b1, 2'b10, 2'b01, 8'd100, 8'd100);
        write_ovr(3'b100);
        // R7 override code 00 decode
        expect_out("R7 override 00", 2'b11, 1'b1, 2'b10, 2'b00, 8'd66, 8'd100);
        write_ovr(3'b001);
        // R8 valid clear returns to straps
        expect_out("R8 valid cleared", 2'b11, 1'b1, 2'b10, 2'b10, 8'd133, 8'd133);
        write_ovr(3'b111);
        // R7 override code 11 decode
        expect_out("R7 override 11", 2'b11, 1'b1, 2'b10, 2'b11, 8'd133, 8'd100);
        rst_n = 1'b0;
        cycles(1);
        rst_n = 1'b1;
        // R9 logic reset clears override valid
        expect_out("R9 reset clears override", 2'b11, 1'b1, 2'b10, 2'b10, 8'd133, 8'd133);

        write_ovr(3'b101);
        supply_good = 1'b0;
        cycles(1);
        // R10 R9 supply loss clears straps, done and override
        expect_out("R10 R9 supply loss", 2'b00, 1'b0, 2'b00, 2'b00, 8'd66, 8'd100);

        pin_in = 2'b11;
        supply_good = 1'b1;
        cycles(WIN / 2);
        supply_good = 1'b0;
        cycles(1);
        supply_good = 1'b1;
        cycles(WIN - 1);
        // R2 dropout restarts the full window
        expect_out("R2 window restarted", 2'b00, 1'b0, 2'b00, 2'b00, 8'd66, 8'd100);
        cycles(1);
        // R1 R4 R7 fresh capture of pins=11
        expect_out("R1 R4 R7 capture 11", 2'b11, 1'b1, 2'b11, 2'b11, 8'd133, 8'd100);

        cycles(2);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule